// File: doc/BRIEF.md
# Lock-Qualified Reset Sequencer with Enable Strobe

This block makes the active-high synchronous reset for user logic that runs on a clock from an on-chip clock manager. The manager's lock flag is the only qualifier. While lock is low, reset is held asserted. That covers the first locking phase and any later loss of the input clock. Once lock rises and stays high, reset is held for a fixed number of derived-clock cycles. It is then released through one extra output flop, so the release is clean in timing.

The lock flag is asynchronous to the derived clock. The block uses it in two ways. First, it is an asynchronous active-low clear for every register, so assertion needs no clock edge. Second, it passes through a short synchronizer before it lets the delay counter advance, so release is always synchronous. The delay is a saturating counter, not a chain of flops. Unknown power-up contents therefore cannot make the reset pulse.

An optional divider produces a clock-enable strobe. The strobe is high for exactly one main-clock cycle in every period, so slow interfaces can run from the main clock without a second clock. The divider is held at zero while reset is asserted.

Top module: `lock_reset_seq`

## Requirements
- R1: `rst_o` is 1 whenever `lock_i` is 0. It goes to 1 as soon as `lock_i` falls, without waiting for a clock edge, and `stb_o` goes to 0 at the same time.
- R2: `lock_i` may rise between rising edge p and edge p+1 and then stay high. `rst_o` stays 1 up to and including edge p+SYNC_STAGES+DELAY_CYCLES, and becomes 0 at edge p+SYNC_STAGES+DELAY_CYCLES+1. That edge count is the synchronizer, the counter and the output flop.
- R3: Whenever `lock_i` falls, the delay count restarts from zero. A high period of `lock_i` shorter than the full delay never releases `rst_o`, and the next rise again waits the whole R2 delay.
- R4: Once released, `rst_o` stays 0 for as long as `lock_i` stays high, because the counter saturates at its terminal value.
- R5: `stb_o` is 0 in every cycle in which `rst_o` is 1.
- R6: The first strobe after release is high exactly STROBE_PERIOD cycles after the edge at which `rst_o` became 0.
- R7: After release, `stb_o` is high for exactly one cycle in every STROBE_PERIOD cycles (STROBE_PERIOD >= 2) and low in all other cycles.
- R8: With STROBE_EN = 0, `stb_o` is constantly 0 and `rst_o` behaves as in R1 to R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Derived clock from the clock manager; clocks every register |
| lock_i | input | 1 | Clock-manager lock flag, asynchronous; low forces reset |
| rst_o | output | 1 | Registered active-high reset for downstream synchronous logic |
| stb_o | output | 1 | Single-cycle clock-enable strobe, one per STROBE_PERIOD cycles |

## Verification
Some properties are checked by assertions on every cycle: the counter never passes its terminal value and steps by one while the synchronized lock is high, it holds once saturated, and the output flop follows the delayed reset one cycle later. The strobe is also checked never to last two cycles and to be cleared one cycle after reset is seen. Other behaviours can only be shown by the bench's scenarios: the exact release edge after a lock rise, the restart after a short lock pulse, the immediate asynchronous assertion when lock drops mid-period, and the placement of the first and later strobes relative to release.

// File: rtl/lrs_pkg.sv
package lrs_pkg;

  // Bits needed to hold any value in 0..max_val (at least one bit).
  function automatic int unsigned bits_for(input int unsigned max_val);
    int unsigned w;
    w = 1;
    while ((max_val >> w) != 0) begin
      w = w + 1;
    end
    return w;
  endfunction

  // Default sizing shared by the top and its submodules.
  localparam int unsigned DEF_SYNC_STAGES   = 2;
  localparam int unsigned DEF_DELAY_CYCLES  = 16;
  localparam int unsigned DEF_STROBE_PERIOD = 8;

endpackage

// File: rtl/lrs_lock_sync.sv
// Brings the asynchronous lock flag into the derived-clock domain.
// Lock low clears every stage at once; a rising lock walks a constant
// one through the chain, so release is always synchronous.
module lrs_lock_sync #(
  parameter int unsigned STAGES = lrs_pkg::DEF_SYNC_STAGES
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic lock_q_o
);

  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  // Next-state: stage 0 samples constant one, later stages copy the previous.
  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_head
        assign stage_d[g] = 1'b1;
      end else begin : g_tail
        assign stage_d[g] = stage_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign lock_q_o = stage_q[STAGES-1];

  // R2: once the synchronized lock is seen, it stays while lock is held
  sync_hold_chk: assert property (@(posedge clk_i) disable iff (!arst_ni)
    lock_q_o |=> lock_q_o);

  // R2: the last stage cannot rise before the first stage has been high
  sync_order_chk: assert property (@(posedge clk_i) disable iff (!arst_ni)
    !stage_q[0] |=> !lock_q_o);

endmodule

// File: rtl/lrs_delay_cnt.sv
// Saturating release counter. Counts derived-clock cycles while the
// synchronized lock is high and flags the end of the hold-off window.
module lrs_delay_cnt #(
  parameter int unsigned DELAY = lrs_pkg::DEF_DELAY_CYCLES
) (
  input  logic clk_i,
  input  logic arst_ni,
  input  logic lock_q_i,
  output logic rst_dly_o
);

  localparam int unsigned CW = lrs_pkg::bits_for(DELAY);
  localparam logic [CW-1:0] TERM = CW'(DELAY);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          at_term;
  logic          cnt_en;

  assign at_term = (cnt_q == TERM);
  assign cnt_en  = lock_q_i && !at_term;

  // Next-state: clear while unlocked, step while counting, hold at terminal.
  always_comb begin
    cnt_d = cnt_q;
    if (!lock_q_i) begin
      cnt_d = '0;
    end else if (cnt_en) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // Reset request stays high until the count has reached its terminal value.
  assign rst_dly_o = !at_term;

  // R4: the count never runs past its terminal value
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!arst_ni)
    cnt_q <= TERM);

  // R4: once saturated with lock held, the count stays put
  cnt_sat_chk: assert property (@(posedge clk_i) disable iff (!arst_ni)
    (at_term && lock_q_i) |=> at_term);

  // R2: while counting, the value advances by exactly one per cycle
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!arst_ni)
    (lock_q_i && !at_term) |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R3: a lost synchronized lock returns the count to zero
  cnt_clear_chk: assert property (@(posedge clk_i) disable iff (!arst_ni)
    !lock_q_i |=> (cnt_q == '0));

endmodule

// File: rtl/lrs_out_reg.sv
// Final timing flop on the reset path. Comes up asserted on lock loss.
module lrs_out_reg (
  input  logic clk_i,
  input  logic arst_ni,
  input  logic rst_dly_i,
  output logic rst_o
);

  logic rst_q;
  logic rst_d;

  always_comb begin
    rst_d = rst_dly_i;
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      rst_q <= 1'b1;
    end else begin
      rst_q <= rst_d;
    end
  end

  assign rst_o = rst_q;

  // R1
  always @(negedge clk_i) begin
    if (!arst_ni) begin
      lock_low_rst_chk: assert (rst_q);
    end
  end

  // R2: a pending request keeps reset asserted one cycle later
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!arst_ni)
    rst_dly_i |=> rst_q);

  // R2: a cleared request releases reset one cycle later
  out_release_chk: assert property (@(posedge clk_i) disable iff (!arst_ni)
    !rst_dly_i |=> !rst_q);

endmodule

// File: rtl/lrs_strobe_div.sv
// Clock-enable divider: one single-cycle strobe every PERIOD cycles,
// held at zero while the hold input (the sequenced reset) is high.
module lrs_strobe_div #(
  parameter int unsigned PERIOD = lrs_pkg::DEF_STROBE_PERIOD
) (
  input  logic clk_i,
  input  logic arst_ni,
  input  logic hold_i,
  output logic stb_o
);

  localparam int unsigned DW = lrs_pkg::bits_for(PERIOD - 1);
  localparam logic [DW-1:0] LAST = DW'(PERIOD - 1);

  logic [DW-1:0] div_q;
  logic [DW-1:0] div_d;
  logic          stb_q;
  logic          stb_d;
  logic          wrap;

  assign wrap = (div_q == LAST);

  // Next-state: zero under hold, otherwise count modulo PERIOD.
  always_comb begin
    div_d = div_q;
    stb_d = 1'b0;
    if (hold_i) begin
      div_d = '0;
    end else if (wrap) begin
      div_d = '0;
      stb_d = 1'b1;
    end else begin
      div_d = div_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      div_q <= '0;
      stb_q <= 1'b0;
    end else begin
      div_q <= div_d;
      stb_q <= stb_d;
    end
  end

  assign stb_o = stb_q;

  // R5: reset seen on an edge leaves no strobe after it
  hold_no_stb_chk: assert property (@(posedge clk_i) disable iff (!arst_ni)
    hold_i |=> !stb_q);

  // R7: a strobe never lasts two cycles
  single_stb_chk: assert property (@(posedge clk_i) disable iff (!arst_ni)
    stb_q |=> !stb_q);

  // R7: the divider restarts from zero right after each strobe
  div_phase_chk: assert property (@(posedge clk_i) disable iff (!arst_ni)
    (stb_q && !hold_i) |-> (div_q == '0));

  // R7: the divider never passes its last phase
  div_bound_chk: assert property (@(posedge clk_i) disable iff (!arst_ni)
    div_q <= LAST);

endmodule

// File: rtl/lock_reset_seq.sv
// Lock-qualified reset sequencer with optional clock-enable strobe.
module lock_reset_seq #(
  parameter int unsigned SYNC_STAGES   = lrs_pkg::DEF_SYNC_STAGES,
  parameter int unsigned DELAY_CYCLES  = lrs_pkg::DEF_DELAY_CYCLES,
  parameter bit          STROBE_EN     = 1'b1,
  parameter int unsigned STROBE_PERIOD = lrs_pkg::DEF_STROBE_PERIOD
) (
  input  logic clk_i,
  input  logic lock_i,
  output logic rst_o,
  output logic stb_o
);

  // Lock low is the asynchronous clear for the whole block.
  logic arst_n;
  logic lock_q;
  logic rst_dly;
  logic rst_q;

  assign arst_n = lock_i;

  lrs_lock_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk_i    (clk_i),
    .arst_ni  (arst_n),
    .lock_q_o (lock_q)
  );

  lrs_delay_cnt #(
    .DELAY (DELAY_CYCLES)
  ) u_cnt (
    .clk_i     (clk_i),
    .arst_ni   (arst_n),
    .lock_q_i  (lock_q),
    .rst_dly_o (rst_dly)
  );

  lrs_out_reg u_out (
    .clk_i     (clk_i),
    .arst_ni   (arst_n),
    .rst_dly_i (rst_dly),
    .rst_o     (rst_q)
  );

  assign rst_o = rst_q;

  generate
    if (STROBE_EN) begin : g_strobe
      lrs_strobe_div #(
        .PERIOD (STROBE_PERIOD)
      ) u_div (
        .clk_i   (clk_i),
        .arst_ni (arst_n),
        .hold_i  (rst_q),
        .stb_o   (stb_o)
      );
    end else begin : g_no_strobe
      assign stb_o = 1'b0;

      // R8
      no_strobe_chk: assert property (@(posedge clk_i) disable iff (!arst_n)
        !stb_o);
    end
  endgenerate

  // R5: the strobe and the reset are never high together
  stb_vs_rst_chk: assert property (@(posedge clk_i) disable iff (!arst_n)
    !(stb_o && rst_o));

endmodule

// File: tb/test_lock_reset_seq.sv
module test_lock_reset_seq;

  localparam int unsigned SYNC   = 2;
  localparam int unsigned DELAY  = 16;
  localparam int unsigned PERIOD = 8;

  typedef struct {
    int    cyc;
    logic  rst;
    logic  stb;
    string rtag;
    string stag;
  } item_t;

  logic clk = 1'b0;
  logic lock = 1'b0;
  logic rst_a, stb_a, rst_b, stb_b;

  int cyc = 0;
  int n_checks = 0;
  int n_fail = 0;
  int rise_cyc = 0;
  logic lock_prev = 1'b0;
  item_t sb_q[$];
  item_t it;

  always #10 clk = ~clk;   // 50 MHz

  always @(posedge clk) cyc <= cyc + 1;

  lock_reset_seq #(
    .SYNC_STAGES(SYNC), .DELAY_CYCLES(DELAY),
    .STROBE_EN(1'b1), .STROBE_PERIOD(PERIOD)
  ) i_lock_reset_seq (
    .clk_i(clk), .lock_i(lock), .rst_o(rst_a), .stb_o(stb_a)
  );

  lock_reset_seq #(
    .SYNC_STAGES(SYNC), .DELAY_CYCLES(DELAY),
    .STROBE_EN(1'b0), .STROBE_PERIOD(PERIOD)
  ) i_nostb (
    .clk_i(clk), .lock_i(lock), .rst_o(rst_b), .stb_o(stb_b)
  );

  task automatic check(input string tag, input string what,
                       input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s at cycle %0d: actual %b expected %b",
               tag, what, cyc, act, exp);
    end
  endtask

  // Driver: sets lock after an edge and queues the expected outputs
  // for this and the following cycles, derived from R1 to R7.
  task automatic drive(input logic lv, input int ncyc, input string hold_tag);
    int p;
    int rel;
    @(posedge clk);
    #5;
    p = cyc;
    lock = lv;
    if (lv && !lock_prev) rise_cyc = p;
    lock_prev = lv;
    if (!lv) begin
      #1;
      check("R1", "async rst_o", rst_a, 1'b1);
      check("R1", "async stb_o", stb_a, 1'b0);
    end
    rel = rise_cyc + SYNC + DELAY + 1;
    for (int k = 0; k < ncyc; k++) begin
      item_t e;
      int t;
      t = p + k;
      e.cyc = t;
      if (!lv) begin
        e.rst = 1'b1;  e.stb = 1'b0;
        e.rtag = "R1"; e.stag = "R5";
      end else if (t < rel) begin
        e.rst = 1'b1;  e.stb = 1'b0;
        e.rtag = hold_tag; e.stag = "R5";
      end else begin
        e.rst = 1'b0;
        e.rtag = (t == rel) ? "R2" : "R4";
        e.stb = (t > rel) && (((t - rel) % PERIOD) == 0);
        e.stag = (t == rel + PERIOD) ? "R6" : "R7";
      end
      sb_q.push_back(e);
    end
    repeat (ncyc - 1) @(posedge clk);
  endtask

  // Monitor: compares queued expectations away from the clock edge.
  always @(negedge clk) begin
    while (sb_q.size() > 0 && sb_q[0].cyc <= cyc) begin
      it = sb_q.pop_front();
      if (it.cyc < cyc) begin
        n_checks++;
        n_fail++;
        $display("FAIL %s stale item for cycle %0d: actual cycle %0d expected %0d",
                 it.rtag, it.cyc, cyc, it.cyc);
      end else begin
        check(it.rtag, "rst_o", rst_a, it.rst);
        check(it.stag, "stb_o", stb_a, it.stb);
        check("R8", "rst_o without strobe", rst_b, it.rst);
        check("R8", "stb_o disabled", stb_b, 1'b0);
      end
    end
  end

  initial begin
    // R1: reset state with lock low from the start
    drive(1'b0, 6, "R1");
    // R2, R6, R7: first lock, release and strobe train
    drive(1'b1, 60, "R2");
    // R1, R5: lock lost in the middle of the strobe train
    drive(1'b0, 5, "R1");
    // R3: lock pulse shorter than the delay never releases
    drive(1'b1, 10, "R3");
    drive(1'b0, 3, "R1");
    // R3, R4: full delay again, then a long saturated stretch
    drive(1'b1, 120, "R3");
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual cycle %0d expected completion earlier", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule